// File: doc/BRIEF.md
# Multicycle Fetch-Execute Sequencer

This block is the hardwired control for a small 32-bit processor that runs one register transfer per clock. It owns sixteen 32-bit user registers. Entry 15 is the program counter, entry 14 is the link register and entry 13 is the stack pointer. It also owns a memory address register, a memory buffer register, an instruction register, two ALU operand latches and a four-bit status register. A fixed state sequence fetches one word from a synchronous read port, checks the op-code, and then executes a register-plus-immediate add.

Instruction word layout:

| Bits | Field |
|------|-------|
| [31:28] | op-code (only 4'h1, add, is supported) |
| [27:21] | ignored |
| [20] | set-flags bit |
| [19:16] | destination register index |
| [15:12] | source register index |
| [11:8] | rotate count |
| [7:0] | 8-bit immediate |

The second operand is the 8-bit immediate, zero-extended to 32 bits and rotated right by twice the rotate count.

The memory port has a read strobe and a valid return. The sequencer holds its request until the data comes back. An op-code other than add stops the sequencer for good and raises an error output. After that only reset restarts it.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is low and after it is released, `pc` is 0, `flags` is 0, `illegal` is 0, and all sixteen registers read as 0. The first read request goes to address 0.
- R2: Every instruction starts with two steps. The first copies `pc` into the address register, which drives `mem_addr`. The second adds 4 to `pc`. The read request is raised only after both. So at the first request after reset, `mem_addr` is 0 and `pc` is 4.
- R3: While waiting for data, `mem_rd` stays high and `mem_addr` stays unchanged until `mem_rvalid` is seen, for any number of stall cycles.
- R4: The fetched word goes through the buffer register into the instruction register. The op-code in bits [31:28] is then checked. Only 4'h1 goes on to execute.
- R5: An add writes the source register plus the rotated immediate to the destination register. In that cycle `wb_en` is high, with `wb_idx` giving the index and `wb_data` the value.
- R6: `flags` is {N,Z,C,V} in bits [3:0]. N is bit 31 of the sum. Z means the sum is zero. C is the carry out of bit 31. V is signed overflow. `flags` is loaded on the write-back edge only when bit 20 is set; otherwise it keeps its value.
- R7: Writing register 15 changes `pc`. The next fetch uses the written value.
- R8: An unsupported op-code sets `illegal`. `illegal` then stays high, no further `mem_rd` or `wb_en` occurs, and `pc` keeps the incremented fetch address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rd | output | 1 | Read request, held until data is valid |
| mem_addr | output | 32 | Read address (memory address register) |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| wb_en | output | 1 | Register write-back this cycle |
| wb_idx | output | 4 | Destination register index |
| wb_data | output | 32 | Value written |
| flags | output | 4 | Status {N,Z,C,V} |
| pc | output | 32 | Program counter (register 15) |
| illegal | output | 1 | Unsupported op-code seen; sequencer halted |

## Verification
The write-back cycle does two things at once: it writes the destination register, and, when the set-flags bit is on, it copies the ALU flags. The harshest case combines both with a destination of register 15, so the write also moves the program counter. The bench provokes this with a flag-setting add into register 15 that jumps past a decoy instruction. It then judges the write-back item, the flags in the following cycle, and which instruction retires next. Flag-setting adds are placed right after non-setting ones, so a stale or skipped flag copy shows up as a mismatch.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int XLEN     = 32;
    localparam int NREG     = 16;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int PC_IDX   = NREG - 1;
    localparam int OPC_W    = 4;
    localparam int OPC_LO   = XLEN - OPC_W;
    localparam int SET_BIT  = 20;
    localparam int RD_LO    = 16;
    localparam int RN_LO    = 12;
    localparam int ROT_W    = 4;
    localparam int ROT_LO   = 8;
    localparam int IMM_W    = 8;
    localparam int IMM_LO   = 0;
    localparam int FLG_W    = 4;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'h1;
    localparam logic [XLEN-1:0]  PC_STEP = 32'd4;

    typedef enum logic [3:0] {
        ST_LDMAR,
        ST_BUMP,
        ST_READ,
        ST_LDIR,
        ST_DECODE,
        ST_OPA,
        ST_OPB,
        ST_ADD,
        ST_WB,
        ST_HALT
    } state_e;

    typedef struct packed {
        state_e             st;
        logic [XLEN-1:0]    mar;
        logic [XLEN-1:0]    mbr;
        logic [XLEN-1:0]    ir;
        logic [OPC_W-1:0]   opc;
        logic [XLEN-1:0]    opa;
        logic [XLEN-1:0]    opb;
        logic [XLEN-1:0]    ans;
        logic [FLG_W-1:0]   aflg;
        logic [FLG_W-1:0]   psr;
        logic               err;
    } ctl_t;
endpackage

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter int W   = 32,
    parameter int N   = 16,
    parameter int PCI = 15,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          pc_we,
    input  logic [W-1:0]  pc_wdata,
    input  logic [IW-1:0] raddr,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  pc_out
);
    logic [W-1:0] ent [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [W-1:0] val;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val <= '0;
            end else if (we && waddr == IW'(i)) begin
                val <= wdata;
            end else if (pc_we && i == PCI) begin
                val <= pc_wdata;
            end
        end
        assign ent[i] = val;
    end

    assign rdata  = ent[raddr];
    assign pc_out = ent[PCI];
endmodule

// File: rtl/seq_opnd.sv
module seq_opnd #(
    parameter int W     = 32,
    parameter int IMMW  = 8,
    parameter int ROTW  = 4
) (
    input  logic [IMMW-1:0] imm,
    input  logic [ROTW-1:0] rot,
    output logic [W-1:0]    opnd
);
    logic [W-1:0]   ext;
    logic [2*W-1:0] dbl;
    logic [ROTW:0]  amt;

    always_comb begin
        ext  = W'(imm);
        amt  = {rot, 1'b0};
        dbl  = {ext, ext} >> amt;
        opnd = dbl[W-1:0];
    end
endmodule

// File: rtl/seq_alu.sv
module seq_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [3:0]   flg
);
    logic [W:0] wide;
    logic       n, z, c, v;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b};
        sum  = wide[W-1:0];
        n    = sum[W-1];
        z    = (sum == '0);
        c    = wide[W];
        v    = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        flg  = {n, z, c, v};
    end
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic [XLEN-1:0]   mem_addr,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_rvalid,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic [FLG_W-1:0]  flags,
    output logic [XLEN-1:0]   pc,
    output logic              illegal
);
    ctl_t q, d;
    state_e state_q;

    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [XLEN-1:0]   rf_wdata;
    logic              pc_we;
    logic [XLEN-1:0]   pc_wdata;
    logic [RIDX_W-1:0] rf_raddr;
    logic [XLEN-1:0]   rf_rdata;
    logic [XLEN-1:0]   pc_val;
    logic [XLEN-1:0]   imm_val;
    logic [XLEN-1:0]   alu_sum;
    logic [FLG_W-1:0]  alu_flg;

    seq_regfile #(.W(XLEN), .N(NREG), .PCI(PC_IDX)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata),
        .pc_we    (pc_we),
        .pc_wdata (pc_wdata),
        .raddr    (rf_raddr),
        .rdata    (rf_rdata),
        .pc_out   (pc_val)
    );

    seq_opnd #(.W(XLEN), .IMMW(IMM_W), .ROTW(ROT_W)) u_opnd (
        .imm  (q.ir[IMM_LO +: IMM_W]),
        .rot  (q.ir[ROT_LO +: ROT_W]),
        .opnd (imm_val)
    );

    seq_alu #(.W(XLEN)) u_alu (
        .a   (q.opa),
        .b   (q.opb),
        .sum (alu_sum),
        .flg (alu_flg)
    );

    // next-state and datapath steering, one register transfer per state
    always_comb begin
        d        = q;
        rf_we    = 1'b0;
        rf_waddr = q.ir[RD_LO +: RIDX_W];
        rf_wdata = q.ans;
        pc_we    = 1'b0;
        pc_wdata = pc_val + PC_STEP;
        rf_raddr = q.ir[RN_LO +: RIDX_W];
        mem_rd   = 1'b0;

        unique case (q.st)
            ST_LDMAR: begin
                d.mar = pc_val;
                d.st  = ST_BUMP;
            end
            ST_BUMP: begin
                pc_we = 1'b1;
                d.st  = ST_READ;
            end
            ST_READ: begin
                mem_rd = 1'b1;
                if (mem_rvalid) begin
                    d.mbr = mem_rdata;
                    d.st  = ST_LDIR;
                end
            end
            ST_LDIR: begin
                d.ir = q.mbr;
                d.st = ST_DECODE;
            end
            ST_DECODE: begin
                d.opc = q.ir[OPC_LO +: OPC_W];
                if (q.ir[OPC_LO +: OPC_W] == OPC_ADD) begin
                    d.st = ST_OPA;
                end else begin
                    d.err = 1'b1;
                    d.st  = ST_HALT;
                end
            end
            ST_OPA: begin
                d.opa = rf_rdata;
                d.st  = ST_OPB;
            end
            ST_OPB: begin
                d.opb = imm_val;
                d.st  = ST_ADD;
            end
            ST_ADD: begin
                d.ans  = alu_sum;
                d.aflg = alu_flg;
                d.st   = ST_WB;
            end
            ST_WB: begin
                rf_we = 1'b1;
                if (q.ir[SET_BIT]) begin
                    d.psr = q.aflg;
                end
                d.st = ST_LDMAR;
            end
            ST_HALT: begin
                d.st = ST_HALT;
            end
            default: begin
                d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_LDMAR;
        end else begin
            q <= d;
        end
    end

    assign state_q  = q.st;
    assign mem_addr = q.mar;
    assign wb_en    = rf_we;
    assign wb_idx   = rf_waddr;
    assign wb_data  = rf_wdata;
    assign flags    = q.psr;
    assign pc       = pc_val;
    assign illegal  = q.err;
endmodule

// File: rtl/fetch_exec_seq_chk.sv
module fetch_exec_seq_chk
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  state_e           st,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  mem_addr,
    input  logic             mem_rd,
    input  logic             mem_rvalid,
    input  logic             wb_en,
    input  logic             illegal,
    input  logic [FLG_W-1:0] flags
);
    p_mar_takes_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LDMAR) |=> (mem_addr == $past(pc)));

    p_pc_bump_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUMP) |=> (pc == $past(pc) + PC_STEP));

    p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

    p_flags_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_en) |=> $stable(flags));

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (illegal && $stable(pc)));

    p_halt_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_rd && !wb_en));
endmodule

bind fetch_exec_seq fetch_exec_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (state_q),
    .pc         (pc),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_rvalid (mem_rvalid),
    .wb_en      (wb_en),
    .illegal    (illegal),
    .flags      (flags)
);

// File: tb/fetch_exec_seq_bench.sv
module fetch_exec_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic [3:0]  flags;
    logic [31:0] pc;
    logic        illegal;

    int total = 0;
    int bad = 0;
    int stall = 0;
    int wait_cnt = 0;
    int addr_slips = 0;

    logic [31:0] mem [64];
    logic [31:0] mdl_r [16];
    logic [3:0]  mdl_f;

    typedef struct packed {
        logic [3:0]  idx;
        logic [31:0] data;
        logic [3:0]  flg;
    } item_t;
    item_t exp_q [$];

    fetch_exec_seq u_fetch_exec_seq (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_data(wb_data), .flags(flags), .pc(pc),
        .illegal(illegal)
    );

    always #5 clk = ~clk;

    // memory model: data valid after (1 + stall) cycles of request
    always @(posedge clk) begin
        if (mem_rd && !mem_rvalid) begin
            if (wait_cnt >= stall) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[7:2]];
                wait_cnt   <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            mem_rvalid <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rot_imm(input logic [3:0] rot, input logic [7:0] imm);
        logic [31:0] v;
        v = {24'd0, imm};
        for (int k = 0; k < 2 * rot; k++) v = {v[0], v[31:1]};
        return v;
    endfunction

    // driver: place an add, and queue its expected retirement when it runs
    task automatic put_add(input int addr, input bit s, input int rd, input int rn,
                           input logic [3:0] rot, input logic [7:0] imm, input bit runs);
        logic [31:0] b, sum;
        logic [32:0] w;
        logic [3:0]  f;
        item_t it;
        mem[addr / 4] = {4'h1, 7'd0, s, 4'(rd), 4'(rn), rot, imm};
        if (runs) begin
            b   = rot_imm(rot, imm);
            w   = {1'b0, mdl_r[rn]} + {1'b0, b};
            sum = w[31:0];
            f   = {sum[31], sum == 32'd0, w[32],
                   (mdl_r[rn][31] == b[31]) && (sum[31] != mdl_r[rn][31])};
            if (s) mdl_f = f;
            mdl_r[rd] = sum;
            it.idx = 4'(rd); it.data = sum; it.flg = mdl_f;
            exp_q.push_back(it);
        end
    endtask

    // monitor: pop expected items at each write-back, flags one cycle later
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (wb_en && rst_n) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected write-back idx", {28'd0, wb_idx}, 32'hFFFF_FFFF);
                end else begin
                    it = exp_q.pop_front();
                    chk("R5 write-back index", {28'd0, wb_idx}, {28'd0, it.idx});
                    chk("R5 write-back data", wb_data, it.data);
                    @(negedge clk);
                    chk("R6 flags after write-back", {28'd0, flags}, {28'd0, it.flg});
                end
            end
        end
    end

    // address must hold while a read is outstanding
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && prev_wait && (!mem_rd || mem_addr !== prev_addr)) addr_slips++;
            prev_wait = rst_n && mem_rd && !mem_rvalid;
            prev_addr = mem_addr;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R8 watchdog: halt not reached actual=running expected=halted");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic model_reset();
        for (int i = 0; i < 16; i++) mdl_r[i] = '0;
        mdl_f = '0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    task automatic start_and_check();
        @(negedge clk);
        chk("R1 pc in reset", pc, 32'd0);
        chk("R1 flags in reset", {28'd0, flags}, 32'd0);
        chk("R1 illegal in reset", {31'd0, illegal}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 no read before bump", {31'd0, mem_rd}, 32'd0);
        @(negedge clk);
        chk("R2 read raised after bump", {31'd0, mem_rd}, 32'd1);
        chk("R1 first address", mem_addr, 32'd0);
        chk("R2 pc bumped by 4", pc, 32'd4);
    endtask

    task automatic finish_halt(input logic [31:0] exp_pc);
        int seen;
        wait (illegal === 1'b1);
        @(negedge clk);
        chk("R8 illegal raised", {31'd0, illegal}, 32'd1);
        chk("R8 pc holds fetch address plus 4", pc, exp_pc);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_rd || wb_en || !illegal) seen++;
        end
        chk("R8 silent after halt", seen, 0);
        chk("R5 all expected adds retired", exp_q.size(), 0);
    endtask

    initial begin
        // program 1: flag cases, jump through R15, then op-code 0
        model_reset();
        stall = 0;
        put_add(32'h00, 1, 1, 0, 4'd4, 8'h80, 1);  // R6 N set
        put_add(32'h04, 0, 2, 1, 4'd4, 8'h80, 1);  // R6 flags kept
        put_add(32'h08, 1, 3, 1, 4'd4, 8'h80, 1);  // R6 Z,C,V
        put_add(32'h0C, 1, 4, 0, 4'd4, 8'h7F, 1);
        put_add(32'h10, 1, 5, 4, 4'd4, 8'h7F, 1);  // R6 N,V
        put_add(32'h14, 1, 15, 0, 4'd0, 8'h40, 1); // R7 jump, flags in same cycle
        put_add(32'h18, 0, 6, 0, 4'd0, 8'h01, 0);  // R7 skipped decoy
        put_add(32'h40, 1, 13, 5, 4'd0, 8'h03, 1);
        put_add(32'h44, 1, 14, 13, 4'd1, 8'hFF, 1); // R6 N,C
        mem[32'h48 / 4] = 32'h0000_0000;           // R4 unsupported op-code
        start_and_check();
        finish_halt(32'h4C);
        chk("R3 address held while waiting", addr_slips, 0);

        // program 2: reset clears registers, stalled memory
        rst_n = 1'b0;
        model_reset();
        stall = 3;
        put_add(32'h00, 1, 2, 1, 4'd0, 8'h05, 1);  // R1 R1 reads 0 after reset
        put_add(32'h04, 0, 2, 2, 4'd0, 8'hFF, 1);
        mem[32'h08 / 4] = 32'hF010_0000;           // R4 op-code 4'hF halts
        repeat (2) @(negedge clk);
        start_and_check();
        finish_halt(32'h0C);
        chk("R3 address held under stalls", addr_slips, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule